// File: doc/BRIEF.md
# Prioritised Interrupt Claim Controller

This block collects level-sensitive interrupt requests from a set of external devices and presents a single interrupt line to each of several processor contexts. Software gives every source a priority and gives every context its own enable mask and priority threshold. While a device holds its request line high and the source is not being serviced, the controller keeps that source marked pending. A context's interrupt line is high whenever at least one pending source that the context enables has a priority strictly above that context's threshold.

A handler services an interrupt in two register accesses. It reads the context's claim register, which returns the ID of the best qualifying source. That read clears the source's pending mark and holds the source out of arbitration. When the handler is done, it writes the same ID to that register. Only then can the device line raise the source again. ID 0 is never a real source and means "nothing to claim". All configuration sits behind a single-cycle register port: read data is combinational, and writes and the claim side effect take place on the clock edge.

Top module: `icc_top`

## Requirements
- R1: After reset all priorities, enables, thresholds and pending bits read as 0, every `ctxIrq` bit is 0, and a claim read returns 0.
- R2: A source with ID from 1 to NUM_SRC-1 whose `srcIrq` bit is high at a clock edge, and which is not claimed-and-uncompleted, reads as pending (bit ID of the word at address 0xC0) from the next cycle on. Bit 0 never sets.
- R3: `ctxIrq[c]` is high exactly when some pending source enabled for context c has priority strictly greater than that context's threshold. A priority equal to the threshold does not qualify.
- R4: A source with priority 0 is never signalled or returned by a claim, whatever the threshold.
- R5: A source whose enable bit is 0 in context c's mask is never signalled to, or claimed by, context c. The enable masks of different contexts are independent.
- R6: A claim read of context c returns the qualifying source with the highest priority. On a tie the lowest ID wins. With no qualifying source it returns 0.
- R7: A claim that returns ID k clears pending bit k at that edge. Bit k stays clear until a completion for k is written, even while `srcIrq[k]` stays high. `ctxIrq` drops in the next cycle if nothing else qualifies.
- R8: Writing ID k to any context's claim/complete address while k is claimed releases k. If its line is still high, k reads pending again two edges after the completion write.
- R9: A completion write whose value is 0, is at least NUM_SRC, or names a source that is not currently claimed changes no state.
- R10: Register map, by word address: 0x00+k gives priority of source k (low PRIO_W bits). 0x40+c gives the enable mask of context c (bit k enables source k; bit 0 reads 0). 0x80+2c gives the threshold of c. 0x81+2c is the claim (read) / complete (write) of c. 0xC0 gives pending (read only). Other addresses read 0 and ignore writes. A cycle with both enables high is a write only.
- R11: A claim read that returns 0 has no side effect on pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | NUM_SRC | Level request per source; bit k is source k, bit 0 unused |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (claim side effect on claim addresses) |
| regAddr | input | 8 | Register word address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data, 0 when no valid read |
| ctxIrq | output | NUM_CTX | Interrupt line per context |

## Verification
The bench targets the threshold boundary where priority equals the threshold. A design using greater-or-equal would raise the line one priority step too early. Ties among sources of equal priority are exercised, so an arbiter that scans from the top ID would return 10 instead of 1. The window between a claim and its completion is held with the device line high. A design without the service mask would re-pend at once, and one that honoured stray completions (wrong ID, ID 0, ID out of range) would re-pend early. Priority-0 sources under a zero threshold and per-context enables are checked as well, along with long random sequences against a bench model.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int IDX_W = 6;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_EN,
    RD_THR,
    RD_CLAIM,
    RD_PEND
  } rdSel_e;

  // Decoded access strobes from control to datapath
  typedef struct packed {
    logic             prioWr;
    logic             enWr;
    logic             thrWr;
    logic             complWr;
    logic             claimRd;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } ctlStrobe_t;

endpackage

// File: rtl/icc_regctl.sv
module icc_regctl
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regAddr,
  output ctlStrobe_t st
);

  localparam logic [6:0] SRC_LIM = 7'(NUM_SRC);
  localparam logic [6:0] CTX_LIM = 7'(NUM_CTX);

  logic       rdGo;
  logic [1:0] region;
  logic [5:0] low;
  logic [4:0] ctxSel;

  assign rdGo   = regRdEn & ~regWrEn;  // write wins (R10)
  assign region = regAddr[7:6];
  assign low    = regAddr[5:0];
  assign ctxSel = regAddr[5:1];

  always_comb begin
    st = '0;
    st.rdSel = RD_NONE;
    unique case (region)
      2'b00: begin
        if (low != '0 && {1'b0, low} < SRC_LIM) begin
          st.prioWr = regWrEn;
          st.rdSel  = rdGo ? RD_PRIO : RD_NONE;
          st.idx    = low;
        end
      end
      2'b01: begin
        if ({1'b0, low} < CTX_LIM) begin
          st.enWr  = regWrEn;
          st.rdSel = rdGo ? RD_EN : RD_NONE;
          st.idx   = low;
        end
      end
      2'b10: begin
        if ({2'b00, ctxSel} < CTX_LIM) begin
          st.idx = {1'b0, ctxSel};
          if (regAddr[0]) begin
            st.complWr = regWrEn;
            st.claimRd = rdGo;
            st.rdSel   = rdGo ? RD_CLAIM : RD_NONE;
          end else begin
            st.thrWr = regWrEn;
            st.rdSel = rdGo ? RD_THR : RD_NONE;
          end
        end
      end
      default: begin
        if (low == '0) st.rdSel = rdGo ? RD_PEND : RD_NONE;
      end
    endcase
  end

  // R10: at most one state-changing action per access
  a_r10_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.prioWr, st.enWr, st.thrWr, st.complWr, st.claimRd}));

  // R10: claim side effect never rides along with a write
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !st.claimRd);

endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0]             en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              thr,
  output logic [ID_W-1:0]                winId,
  output logic                           winValid
);

  logic [PRIO_W-1:0] bestPrio;

  // Ascending scan with strict compare: ties keep the lowest ID,
  // and starting from the threshold enforces prio > thr (so prio 0 never wins)
  always_comb begin
    bestPrio = thr;
    winId    = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (pend[i] && en[i] && prio[i] > bestPrio) begin
        bestPrio = prio[i];
        winId    = ID_W'(i);
      end
    end
  end

  assign winValid = (winId != '0);

endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  ctlStrobe_t         st,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CTX-1:0] ctxIrq
);

  localparam logic [NUM_SRC-1:0] SRC_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

  logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] enQ;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thrQ;
  logic [NUM_SRC-1:0]              pendQ, pendD;
  logic [NUM_SRC-1:0]              busyQ, busyD;
  logic [NUM_CTX-1:0][ID_W-1:0]    winId;

  logic [ID_W-1:0] claimId;
  logic            claimValid;
  logic [ID_W-1:0] complId;
  logic            complHit;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    icc_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W)
    ) u_arb (
      .pend     (pendQ),
      .en       (enQ[c]),
      .prio     (prioQ),
      .thr      (thrQ[c]),
      .winId    (winId[c]),
      .winValid (ctxIrq[c])
    );
  end

  always_comb begin
    claimId = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (st.idx == IDX_W'(c)) claimId = winId[c];
    end
  end
  assign claimValid = st.claimRd && (claimId != '0);

  assign complId  = wrData[ID_W-1:0];
  assign complHit = st.complWr && (wrData[DATA_W-1:ID_W] == '0) &&
                    (complId != '0) && busyQ[complId];

  // Gateway: level sets pending unless the source is being serviced
  always_comb begin
    pendD = pendQ | (srcIrq & ~busyQ & SRC_MASK);
    busyD = busyQ;
    if (claimValid) begin
      pendD[claimId] = 1'b0;
      busyD[claimId] = 1'b1;
    end
    if (complHit) busyD[complId] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioQ <= '0;
      enQ   <= '0;
      thrQ  <= '0;
      pendQ <= '0;
      busyQ <= '0;
    end else begin
      pendQ <= pendD;
      busyQ <= busyD;
      for (int i = 1; i < NUM_SRC; i++) begin
        if (st.prioWr && st.idx == IDX_W'(i)) prioQ[i] <= wrData[PRIO_W-1:0];
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        if (st.enWr && st.idx == IDX_W'(c)) enQ[c] <= wrData[NUM_SRC-1:0] & SRC_MASK;
        if (st.thrWr && st.idx == IDX_W'(c)) thrQ[c] <= wrData[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (st.rdSel)
      RD_PRIO: begin
        for (int i = 1; i < NUM_SRC; i++)
          if (st.idx == IDX_W'(i)) rdData[PRIO_W-1:0] = prioQ[i];
      end
      RD_EN: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (st.idx == IDX_W'(c)) rdData[NUM_SRC-1:0] = enQ[c];
      end
      RD_THR: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (st.idx == IDX_W'(c)) rdData[PRIO_W-1:0] = thrQ[c];
      end
      RD_CLAIM: rdData[ID_W-1:0] = claimId;
      RD_PEND:  rdData[NUM_SRC-1:0] = pendQ;
      default:  rdData = '0;
    endcase
  end

  // R7: a successful claim leaves the source not pending and in service
  a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |=> (!pendQ[$past(claimId)] && busyQ[$past(claimId)]));

  // R9: a completion that misses leaves the service mask untouched
  a_r9_stray_complete: assert property (@(posedge clk) disable iff (!rstN)
    (st.complWr && !complHit) |=> (busyQ == $past(busyQ)));

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src_chk
    // R7: a source in service is never pending
    a_r7_busy_not_pend: assert property (@(posedge clk) disable iff (!rstN)
      busyQ[i] |-> !pendQ[i]);
    // R2: a high line on an idle source becomes pending
    a_r2_line_sets: assert property (@(posedge clk) disable iff (!rstN)
      (srcIrq[i] && !busyQ[i] && !(claimValid && claimId == ID_W'(i))) |=> pendQ[i]);
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
    // R3 R5: a raised line names an enabled pending source above threshold
    a_r3_irq_qualified: assert property (@(posedge clk) disable iff (!rstN)
      ctxIrq[c] |-> (pendQ[winId[c]] && enQ[c][winId[c]] &&
                     prioQ[winId[c]] > thrQ[c]));
  end

endmodule

// File: rtl/icc_top.sv
module icc_top
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [7:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_CTX-1:0] ctxIrq
);

  ctlStrobe_t st;

  icc_regctl #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .st      (st)
  );

  icc_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIrq (srcIrq),
    .st     (st),
    .wrData (regWrData),
    .rdData (regRdData),
    .ctxIrq (ctxIrq)
  );

endmodule

// File: tb/tb_icc_top.sv
`timescale 1ns/1ps
module tb_icc_top;

  localparam int NS = 16;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcIrq = '0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [7:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NC-1:0] ctxIrq;

  int checks = 0;
  int failures = 0;

  int unsigned mPrio[NS];
  bit [NS-1:0] mEn[NC];
  int unsigned mThr[NC];
  bit [NS-1:0] mPend, mBusy, mLines;

  icc_top dut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ctxIrq(ctxIrq)
  );

  always #2 clk = ~clk;

  function automatic int winner(int c);
    int unsigned best = mThr[c];
    int id = 0;
    for (int i = 1; i < NS; i++)
      if (mPend[i] && mEn[c][i] && mPrio[i] > best) begin
        best = mPrio[i];
        id = i;
      end
    return id;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    int low = int'(a[5:0]);
    int cx  = int'(a[5:1]);
    case (a[7:6])
      2'b00: return (low >= 1 && low < NS) ? 32'(mPrio[low]) : 32'd0;
      2'b01: return (low < NC) ? 32'(mEn[low]) : 32'd0;
      2'b10: if (cx < NC) return a[0] ? 32'(winner(cx)) : 32'(mThr[cx]);
             else return 32'd0;
      default: return (low == 0) ? 32'(mPend) : 32'd0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(bit wr, bit rd, logic [7:0] a, logic [31:0] d, string tag);
    int low, cx, w;
    bit [NS-1:0] nPend, nBusy;
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d; srcIrq = mLines;
    #1;
    for (int c = 0; c < NC; c++)
      check(ctxIrq[c] === (winner(c) != 0), {tag, " irq"},
            32'(ctxIrq[c]), 32'(winner(c) != 0));
    if (rd && !wr) check(regRdData === expRead(a), {tag, " read"}, regRdData, expRead(a));
    @(posedge clk);
    low = int'(a[5:0]);
    cx  = int'(a[5:1]);
    nPend = mPend | (mLines & ~mBusy & 16'hFFFE);
    nBusy = mBusy;
    if (a[7:6] == 2'b10 && cx < NC && a[0] && rd && !wr) begin
      w = winner(cx);
      if (w != 0) begin nPend[w] = 1'b0; nBusy[w] = 1'b1; end
    end
    if (wr) begin
      case (a[7:6])
        2'b00: if (low >= 1 && low < NS) mPrio[low] = d & 32'h7;
        2'b01: if (low < NC) mEn[low] = d[NS-1:0] & 16'hFFFE;
        2'b10: if (cx < NC) begin
          if (!a[0]) mThr[cx] = d & 32'h7;
          else if (d != 0 && d < NS && mBusy[d]) nBusy[d] = 1'b0;
        end
        default: ;
      endcase
    end
    mPend = nPend;
    mBusy = nBusy;
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d, string tag);
    tick(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rdReg(logic [7:0] a, string tag);
    tick(1'b0, 1'b1, a, 32'd0, tag);
  endtask
  task automatic idle(string tag);
    tick(1'b0, 1'b0, 8'h3F, 32'd0, tag);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) mPrio[i] = 0;
    for (int c = 0; c < NC; c++) begin mEn[c] = '0; mThr[c] = 0; end
    mPend = '0; mBusy = '0; mLines = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(8'h01, "R1"); rdReg(8'h40, "R1"); rdReg(8'h80, "R1");
    rdReg(8'h81, "R1"); rdReg(8'h83, "R1"); rdReg(8'hC0, "R1");

    // R10 register map and readback
    wrReg(8'h0A, 32'd5, "R10"); rdReg(8'h0A, "R10");
    wrReg(8'h40, 32'hFFFF, "R10"); rdReg(8'h40, "R10");
    wrReg(8'h82, 32'd7, "R10"); rdReg(8'h82, "R10");
    wrReg(8'h00, 32'd3, "R10"); rdReg(8'h00, "R10");
    wrReg(8'h82, 32'd0, "R10");
    wrReg(8'h41, 32'hFFFF, "R10");

    // R4 priority 0 never delivered; R11 empty claim has no effect
    mLines[3] = 1'b1;
    wrReg(8'h03, 32'd0, "R4");
    idle("R2"); rdReg(8'hC0, "R2");
    rdReg(8'h81, "R4"); rdReg(8'h83, "R11"); rdReg(8'hC0, "R11");

    // R3 strict threshold
    wrReg(8'h03, 32'd2, "R3"); wrReg(8'h80, 32'd2, "R3");
    idle("R3"); idle("R3");
    wrReg(8'h80, 32'd1, "R3"); idle("R3");

    // R6 tie -> lowest ID, then higher priority wins
    wrReg(8'h01, 32'd2, "R6"); wrReg(8'h0A, 32'd2, "R6");
    mLines[1] = 1'b1; mLines[10] = 1'b1;
    idle("R6"); rdReg(8'h81, "R6");
    wrReg(8'h0A, 32'd6, "R6"); rdReg(8'h83, "R6");

    // R7 claimed source stays clear while line held
    idle("R7"); idle("R7"); rdReg(8'hC0, "R7");

    // R9 stray completions ignored
    wrReg(8'h81, 32'd5, "R9"); wrReg(8'h81, 32'd0, "R9");
    wrReg(8'h81, 32'd26, "R9"); idle("R9"); rdReg(8'hC0, "R9");
    tick(1'b1, 1'b1, 8'h83, 32'd4, "R10"); rdReg(8'hC0, "R10");

    // R8 completion releases; line still high -> pending again
    wrReg(8'h83, 32'd10, "R8"); idle("R8"); rdReg(8'hC0, "R8");
    rdReg(8'h83, "R8");

    // R5 per-context enables
    wrReg(8'h40, 32'h0000, "R5"); idle("R5"); rdReg(8'h81, "R5");
    wrReg(8'h40, 32'h0400, "R5"); wrReg(8'h41, 32'h0002, "R5");
    idle("R5"); rdReg(8'h81, "R5"); rdReg(8'h83, "R5");

    // Random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom % 9);
      if ($urandom % 4 == 0) mLines[$urandom % NS] = 1'($urandom);
      case (op)
        0: wrReg(8'($urandom % 18), $urandom % 8, "R10");
        1: wrReg(8'h40 + 8'($urandom % 3), $urandom, "R5");
        2: wrReg(8'h80 + 8'(2 * ($urandom % 3)), $urandom % 8, "R3");
        3, 4: rdReg(8'h81 + 8'(2 * ($urandom % 2)), "R6");
        5: wrReg(8'h81 + 8'(2 * ($urandom % 2)),
                 ($urandom % 3 == 0) ? $urandom % 40 : $urandom % 16, "R8");
        6: rdReg(8'hC0, "R2");
        7: tick(1'($urandom), 1'($urandom), 8'($urandom), $urandom % 16, "R10");
        default: idle("R3");
      endcase
    end

    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule